// File: doc/BRIEF.md
# Power domain collapse sequencer

This block gates power to one switchable logic domain on a slow reference clock. Software programs a single control word that holds the collapse request, the hardware-trigger and override options, and three wait exponents. A state machine then walks the domain down or up through a fixed series of steps. Each gap between steps lasts a programmable 2^n cycles. A separate read-only flag reports when the domain has settled fully on or fully off.

The block drives every control that a power-gated region needs: the domain clock enable, the output clamp, two banks of power switches (a small "few" bank brought up first and then the "rest"), an active-low domain reset and a memory/peripheral retention force. In hardware-trigger mode a request pin replaces the software bit as the source of the request. While the override bit is set, no new sequence starts.

Top module: `pwr_gate_seq`

## Requirements
- R1: After reset the domain is collapsed: clock enable 0, clamp 1, both switch banks 0, domain reset asserted (0), retention 0, status 0. The control word reads 0x0022_2001.
- R2: Control word fields: bit 0 collapse request (1 = off, 0 = on), bit 1 hardware-trigger mode, bit 2 override, bits 23:20 rest wait, bits 19:16 few wait, bits 15:12 clock wait. A field value n gives 2^n cycles. Writable fields read back as written and all other bits except bit 31 read 0.
- R3: Once the machine accepts a request it waits 8 cycles (START_DLY) before any output moves. For a software write this is 2 + 8 cycles after the write edge. For a hardware pin change it is 1 + 8 cycles after the pin changes.
- R4: Power-up, each step at the given offset from the previous one: clamp released. After the clock wait the few bank turns on. After the few wait the rest bank turns on. After the rest wait the reset is released and retention is forced on. After CLK_HOLD (8) cycles the clock is enabled and the status becomes 1.
- R5: Power-down, each step at the given offset from the previous one: clock disabled and retention cleared. After the clock wait both switch banks turn off and the reset asserts. After the rest wait the clamp asserts. After the clock wait the status becomes 0.
- R6: Status is 1 only once power-up has finished and stays 1 through a power-down until the final wait ends.
- R7: The clock enable stays low for at least CLK_HOLD cycles after the domain reset is released.
- R8: With bit 1 set, the request pin (1 = power on) alone selects the target and the collapse bit has no effect. With bit 1 clear, the pin has no effect.
- R9: While the override bit is set, no sequence starts from a settled state. Clearing it starts the pending request.
- R10: A request changed mid-sequence does not alter that sequence. If the request then differs from the settled state, the opposite sequence starts on the next cycle.
- R11: Bit 31 of the read data equals the status output, and writes to it are ignored.
- R12: The clamp is never asserted while either switch bank is on. The rest bank is on only with the few bank. The clock is enabled only with both banks on, reset released and clamp off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word write data |
| hw_on_req | input | 1 | Hardware power request, 1 = on (used in hardware-trigger mode) |
| clk_en | output | 1 | Domain clock enable |
| clamp_en | output | 1 | Output clamp, 1 = clamped |
| sw_few_en | output | 1 | First power switch bank enable |
| sw_rest_en | output | 1 | Remaining power switch bank enable |
| dom_rst_n | output | 1 | Active-low domain reset |
| retain_en | output | 1 | Memory and peripheral retention force |
| pwr_on_status | output | 1 | Settled power-on status |
| rd_data | output | 32 | Control word read data with status in bit 31 |

## Verification
A scoreboard predicts the exact cycle and output pattern of every step from the programmed exponents, so a design that mixes up which field times which gap, or adds a register stage, lands on the wrong edge. Unequal exponents, including a zero (single-cycle) wait and a 1024-cycle wait, expose a swapped or truncated field. A request flipped in the middle of a power-up catches a design that aborts the sequence or loses the pending request. Override, hardware-trigger mode and writes to the status bit are each tested by holding the settled state and flagging any output change that the block should not make.

// File: rtl/pwr_gate_pkg.sv
package pwr_gate_pkg;

  localparam int unsigned WAIT_W    = 4;
  localparam int unsigned REG_W     = 32;
  localparam int unsigned BIT_COLL  = 0;
  localparam int unsigned BIT_HW    = 1;
  localparam int unsigned BIT_OVR   = 2;
  localparam int unsigned LSB_WCLK  = 12;
  localparam int unsigned LSB_WFEW  = 16;
  localparam int unsigned LSB_WREST = 20;
  localparam int unsigned BIT_STAT  = 31;
  localparam logic [WAIT_W-1:0] WAIT_RST = 4'd2;

  typedef struct packed {
    logic [WAIT_W-1:0] w_rest;
    logic [WAIT_W-1:0] w_few;
    logic [WAIT_W-1:0] w_clk;
    logic              ovr;
    logic              hw;
    logic              coll;
  } ctrl_t;

  typedef enum logic [3:0] {
    S_OFF,
    S_UP_START,
    S_UP_UNCLAMP,
    S_UP_FEW,
    S_UP_REST,
    S_UP_RST,
    S_ON,
    S_DN_START,
    S_DN_CLKOFF,
    S_DN_SWOFF,
    S_DN_CLAMP
  } seq_state_t;

  typedef struct packed {
    logic clk_en;
    logic clamp;
    logic few;
    logic rest;
    logic rst_n;
    logic retain;
  } dom_ctl_t;

endpackage

// File: rtl/pgs_ctrl_reg.sv
module pgs_ctrl_reg
  import pwr_gate_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             status,
  output ctrl_t            ctrl,
  output logic [REG_W-1:0] rd_data
);

  ctrl_t ctrl_q;
  ctrl_t ctrl_d;

  always_comb begin
    ctrl_d        = ctrl_q;
    ctrl_d.coll   = wr_data[BIT_COLL];
    ctrl_d.hw     = wr_data[BIT_HW];
    ctrl_d.ovr    = wr_data[BIT_OVR];
    ctrl_d.w_clk  = wr_data[LSB_WCLK +: WAIT_W];
    ctrl_d.w_few  = wr_data[LSB_WFEW +: WAIT_W];
    ctrl_d.w_rest = wr_data[LSB_WREST +: WAIT_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '{w_rest: WAIT_RST, w_few: WAIT_RST, w_clk: WAIT_RST,
                  ovr: 1'b0, hw: 1'b0, coll: 1'b1};
    end else if (wr_en) begin
      ctrl_q <= ctrl_d;
    end
  end

  always_comb begin
    rd_data                         = '0;
    rd_data[BIT_COLL]               = ctrl_q.coll;
    rd_data[BIT_HW]                 = ctrl_q.hw;
    rd_data[BIT_OVR]                = ctrl_q.ovr;
    rd_data[LSB_WCLK +: WAIT_W]     = ctrl_q.w_clk;
    rd_data[LSB_WFEW +: WAIT_W]     = ctrl_q.w_few;
    rd_data[LSB_WREST +: WAIT_W]    = ctrl_q.w_rest;
    rd_data[BIT_STAT]               = status;
  end

  assign ctrl = ctrl_q;

endmodule

// File: rtl/pgs_wait_timer.sv
module pgs_wait_timer #(
  parameter int unsigned CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [CNT_W-1:0] len,
  output logic             expired
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign expired = (cnt_q == (len - ONE));
  assign cnt_en  = restart || !expired;
  assign cnt_d   = restart ? '0 : (cnt_q + ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/pgs_fsm.sv
module pgs_fsm
  import pwr_gate_pkg::*;
#(
  parameter int unsigned START_DLY = 8,
  parameter int unsigned CLK_HOLD  = 8,
  parameter int unsigned CNT_W     = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrl_t            ctrl,
  input  logic             hw_on_req,
  input  logic             expired,
  output logic             restart,
  output logic [CNT_W-1:0] len,
  output dom_ctl_t         dom,
  output logic             status
);

  localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);
  localparam logic [CNT_W-1:0] LEN_START = CNT_W'(START_DLY);
  localparam logic [CNT_W-1:0] LEN_HOLD  = CNT_W'(CLK_HOLD);

  seq_state_t state_q;
  seq_state_t state_nxt;
  logic       status_q;
  logic       status_d;
  logic       status_en;
  logic       want_off;
  logic       may_start;

  function automatic logic [CNT_W-1:0] pow2(input logic [WAIT_W-1:0] n);
    return ONE << n;
  endfunction

  assign want_off  = ctrl.hw ? !hw_on_req : ctrl.coll;
  assign may_start = !ctrl.ovr;

  always_comb begin
    state_nxt = state_q;
    len       = ONE;
    unique case (state_q)
      S_OFF:        if (may_start && !want_off) state_nxt = S_UP_START;
      S_UP_START: begin
        len = LEN_START;
        if (expired) state_nxt = S_UP_UNCLAMP;
      end
      S_UP_UNCLAMP: begin
        len = pow2(ctrl.w_clk);
        if (expired) state_nxt = S_UP_FEW;
      end
      S_UP_FEW: begin
        len = pow2(ctrl.w_few);
        if (expired) state_nxt = S_UP_REST;
      end
      S_UP_REST: begin
        len = pow2(ctrl.w_rest);
        if (expired) state_nxt = S_UP_RST;
      end
      S_UP_RST: begin
        len = LEN_HOLD;
        if (expired) state_nxt = S_ON;
      end
      S_ON:         if (may_start && want_off) state_nxt = S_DN_START;
      S_DN_START: begin
        len = LEN_START;
        if (expired) state_nxt = S_DN_CLKOFF;
      end
      S_DN_CLKOFF: begin
        len = pow2(ctrl.w_clk);
        if (expired) state_nxt = S_DN_SWOFF;
      end
      S_DN_SWOFF: begin
        len = pow2(ctrl.w_rest);
        if (expired) state_nxt = S_DN_CLAMP;
      end
      S_DN_CLAMP: begin
        len = pow2(ctrl.w_clk);
        if (expired) state_nxt = S_OFF;
      end
      default:      state_nxt = S_OFF;
    endcase
  end

  assign restart = (state_nxt != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_OFF;
    end else begin
      state_q <= state_nxt;
    end
  end

  // settled status only moves when a sequence lands in a stable state
  assign status_en = restart && ((state_nxt == S_ON) || (state_nxt == S_OFF));
  assign status_d  = (state_nxt == S_ON);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= 1'b0;
    end else if (status_en) begin
      status_q <= status_d;
    end
  end

  assign status = status_q;

  always_comb begin
    dom = '{clk_en: 1'b0, clamp: 1'b1, few: 1'b0, rest: 1'b0,
            rst_n: 1'b0, retain: 1'b0};
    unique case (state_q)
      S_OFF, S_UP_START: ;
      S_UP_UNCLAMP: dom.clamp = 1'b0;
      S_UP_FEW: begin
        dom.clamp = 1'b0;
        dom.few   = 1'b1;
      end
      S_UP_REST: begin
        dom.clamp = 1'b0;
        dom.few   = 1'b1;
        dom.rest  = 1'b1;
      end
      S_UP_RST: begin
        dom.clamp  = 1'b0;
        dom.few    = 1'b1;
        dom.rest   = 1'b1;
        dom.rst_n  = 1'b1;
        dom.retain = 1'b1;
      end
      S_ON, S_DN_START: begin
        dom.clk_en = 1'b1;
        dom.clamp  = 1'b0;
        dom.few    = 1'b1;
        dom.rest   = 1'b1;
        dom.rst_n  = 1'b1;
        dom.retain = 1'b1;
      end
      S_DN_CLKOFF: begin
        dom.clamp = 1'b0;
        dom.few   = 1'b1;
        dom.rest  = 1'b1;
        dom.rst_n = 1'b1;
      end
      S_DN_SWOFF:   dom.clamp = 1'b0;
      S_DN_CLAMP:   ;
      default:      ;
    endcase
  end

endmodule

// File: rtl/pwr_gate_seq.sv
module pwr_gate_seq
  import pwr_gate_pkg::*;
#(
  parameter int unsigned START_DLY = 8,
  parameter int unsigned CLK_HOLD  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             hw_on_req,
  output logic             clk_en,
  output logic             clamp_en,
  output logic             sw_few_en,
  output logic             sw_rest_en,
  output logic             dom_rst_n,
  output logic             retain_en,
  output logic             pwr_on_status,
  output logic [REG_W-1:0] rd_data
);

  localparam int unsigned CNT_W = (1 << WAIT_W) + 1;

  ctrl_t            ctrl;
  dom_ctl_t         dom;
  logic             status;
  logic             restart;
  logic             expired;
  logic [CNT_W-1:0] len;

  pgs_ctrl_reg u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .status  (status),
    .ctrl    (ctrl),
    .rd_data (rd_data)
  );

  pgs_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .len     (len),
    .expired (expired)
  );

  pgs_fsm #(
    .START_DLY (START_DLY),
    .CLK_HOLD  (CLK_HOLD),
    .CNT_W     (CNT_W)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl      (ctrl),
    .hw_on_req (hw_on_req),
    .expired   (expired),
    .restart   (restart),
    .len       (len),
    .dom       (dom),
    .status    (status)
  );

  assign clk_en        = dom.clk_en;
  assign clamp_en      = dom.clamp;
  assign sw_few_en     = dom.few;
  assign sw_rest_en    = dom.rest;
  assign dom_rst_n     = dom.rst_n;
  assign retain_en     = dom.retain;
  assign pwr_on_status = status;

endmodule

// File: rtl/pwr_gate_seq_chk.sv
module pwr_gate_seq_chk #(
  parameter int unsigned CLK_HOLD = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        clk_en,
  input logic        clamp_en,
  input logic        sw_few_en,
  input logic        sw_rest_en,
  input logic        dom_rst_n,
  input logic        retain_en,
  input logic        pwr_on_status,
  input logic [31:0] rd_data
);

  logic [7:0] hold_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_cnt <= '0;
    end else if (!dom_rst_n) begin
      hold_cnt <= '0;
    end else if (!clk_en && (hold_cnt != 8'hFF)) begin
      hold_cnt <= hold_cnt + 8'd1;
    end
  end

  a_r12_clamp_excl: assert property (@(posedge clk) disable iff (!rst_n)
    clamp_en |-> (!sw_few_en && !sw_rest_en));
  a_r12_rest_needs_few: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rest_en |-> sw_few_en);
  a_r12_clk_full_up: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en |-> (sw_rest_en && dom_rst_n && !clamp_en));
  a_r5_rst_when_unpowered: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_few_en |-> !dom_rst_n);
  a_r4_unclamp_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_few_en) |-> $past(!clamp_en));
  a_r5_clamp_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clamp_en) |-> $past(!sw_few_en && !sw_rest_en));
  a_r6_status_on_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_on_status) |-> (clk_en && retain_en));
  a_r6_status_off_full: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_on_status) |-> (clamp_en && !dom_rst_n));
  a_r7_clk_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_en) |-> (hold_cnt >= CLK_HOLD));
  a_r11_status_readback: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[31] == pwr_on_status);

endmodule

bind pwr_gate_seq pwr_gate_seq_chk #(.CLK_HOLD(CLK_HOLD)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .clk_en        (clk_en),
  .clamp_en      (clamp_en),
  .sw_few_en     (sw_few_en),
  .sw_rest_en    (sw_rest_en),
  .dom_rst_n     (dom_rst_n),
  .retain_en     (retain_en),
  .pwr_on_status (pwr_on_status),
  .rd_data       (rd_data)
);

// File: tb/pwr_gate_seq_bench.sv
module pwr_gate_seq_bench;

  localparam int unsigned SDLY = 8;
  localparam int unsigned HOLD = 8;
  // vector order {clk_en, clamp, few, rest, rst_n, retain, status}
  localparam logic [6:0] V_OFF     = 7'b0100000;
  localparam logic [6:0] V_UNCLAMP = 7'b0000000;
  localparam logic [6:0] V_FEW     = 7'b0010000;
  localparam logic [6:0] V_REST    = 7'b0011000;
  localparam logic [6:0] V_RST     = 7'b0011110;
  localparam logic [6:0] V_ON      = 7'b1011111;
  localparam logic [6:0] V_CLKOFF  = 7'b0011101;
  localparam logic [6:0] V_SWOFF   = 7'b0000001;
  localparam logic [6:0] V_CLAMP   = 7'b0100001;

  typedef struct packed {
    logic [31:0] at;
    logic [6:0]  v;
  } exp_t;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [31:0] wr_data;
  logic        hw_on_req;
  logic        clk_en, clamp_en, sw_few_en, sw_rest_en, dom_rst_n, retain_en, pwr_on_status;
  logic [31:0] rd_data;
  logic [6:0]  vec;
  logic [31:0] cyc;

  int unsigned checks;
  int unsigned failures;
  bit          mon_en;
  bit          finished;
  logic [6:0]  prev_vec;
  exp_t        exp_q[$];

  pwr_gate_seq u_pwr_gate_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .hw_on_req(hw_on_req),
    .clk_en(clk_en), .clamp_en(clamp_en), .sw_few_en(sw_few_en), .sw_rest_en(sw_rest_en),
    .dom_rst_n(dom_rst_n), .retain_en(retain_en), .pwr_on_status(pwr_on_status),
    .rd_data(rd_data)
  );

  assign vec = {clk_en, clamp_en, sw_few_en, sw_rest_en, dom_rst_n, retain_en, pwr_on_status};

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) cyc <= (rst_n ? cyc + 32'd1 : 32'd0);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // monitor: every output change must match the next predicted step, in cycle and value
  always @(negedge clk) begin
    if (rst_n && mon_en) begin
      if (vec !== prev_vec) begin
        if (exp_q.size() == 0) begin
          checks++;
          failures++;
          $display("FAIL R9/R10/R8 unexpected change at %0d actual=%b expected=%b", cyc, vec, prev_vec);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          checks++;
          // R3 start delay, R4 up order, R5 down order, R6 status, R7 clock hold, R12
          if (e.at != cyc || e.v !== vec) begin
            failures++;
            $display("FAIL R3/R4/R5/R6/R7/R12 step actual=%0d:%b expected=%0d:%b",
                     cyc, vec, e.at, e.v);
          end
        end
      end
      prev_vec = vec;
    end
  end

  task automatic push(input logic [31:0] at, input logic [6:0] v);
    exp_t e;
    e.at = at;
    e.v  = v;
    exp_q.push_back(e);
  endtask

  task automatic push_up(input logic [31:0] s, input int unsigned wc, input int unsigned wf,
                         input int unsigned wr, output logic [31:0] done);
    logic [31:0] e;
    e = s + SDLY;         push(e, V_UNCLAMP);
    e = e + (32'd1 << wc); push(e, V_FEW);
    e = e + (32'd1 << wf); push(e, V_REST);
    e = e + (32'd1 << wr); push(e, V_RST);
    e = e + HOLD;         push(e, V_ON);
    done = e;
  endtask

  task automatic push_down(input logic [31:0] s, input int unsigned wc, input int unsigned wr,
                           output logic [31:0] done);
    logic [31:0] e;
    e = s + SDLY;         push(e, V_CLKOFF);
    e = e + (32'd1 << wc); push(e, V_SWOFF);
    e = e + (32'd1 << wr); push(e, V_CLAMP);
    e = e + (32'd1 << wc); push(e, V_OFF);
    done = e;
  endtask

  task automatic cfg_write(input logic [31:0] d, output logic [31:0] c0);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = d;
    c0      = cyc;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic set_hw(input logic v, output logic [31:0] c0);
    @(negedge clk);
    hw_on_req = v;
    c0        = cyc;
  endtask

  task automatic wait_idle();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic hold_check(input int unsigned n, input logic [6:0] v, input string req);
    repeat (n) @(negedge clk);
    check(vec === v && exp_q.size() == 0, req, {25'd0, vec}, {25'd0, v});
  endtask

  initial begin
    checks = 0;
    failures = 0;
    finished = 1'b0;
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog all-requirements actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] c0;
    logic [31:0] c1;
    logic [31:0] dn;
    mon_en    = 1'b0;
    rst_n     = 1'b0;
    wr_en     = 1'b0;
    wr_data   = '0;
    hw_on_req = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(vec === V_OFF, "R1 reset outputs", {25'd0, vec}, {25'd0, V_OFF});
    check(rd_data === 32'h0022_2001, "R1 reset control word", rd_data, 32'h0022_2001);
    prev_vec = vec;
    mon_en   = 1'b1;

    // R4 power-up with default waits, R3 start delay
    cfg_write(32'h0022_2000, c0);
    push_up(c0 + 2, 2, 2, 2, dn);
    wait_idle();
    check(rd_data[31] === 1'b1, "R11 status readback on", {31'd0, rd_data[31]}, 32'd1);

    // R5 power-down with default waits
    cfg_write(32'h0022_2001, c0);
    push_down(c0 + 2, 2, 2, dn);
    wait_idle();
    check(rd_data[31] === 1'b0, "R11 status readback off", {31'd0, rd_data[31]}, 32'd0);

    // R2 unequal waits: rest n=1, few n=3, clock n=0
    cfg_write(32'h0013_0000, c0);
    check(rd_data === 32'h0013_0000, "R2 field readback", rd_data, 32'h0013_0000);
    push_up(c0 + 2, 0, 3, 1, dn);
    wait_idle();
    cfg_write(32'h0013_0001, c0);
    push_down(c0 + 2, 0, 1, dn);
    wait_idle();

    // R10 request reversed mid power-up
    cfg_write(32'h0013_0000, c0);
    push_up(c0 + 2, 0, 3, 1, dn);
    repeat (3) @(negedge clk);
    cfg_write(32'h0013_0001, c1);
    push_down(dn + 1, 0, 1, dn);
    wait_idle();

    // R9 override blocks a new sequence, clearing it releases the request
    cfg_write(32'h0013_0004, c0);
    hold_check(40, V_OFF, "R9 override holds off");
    cfg_write(32'h0013_0000, c0);
    push_up(c0 + 2, 0, 3, 1, dn);
    wait_idle();

    // R8 pin ignored in software mode
    set_hw(1'b1, c0);
    hold_check(20, V_ON, "R8 pin ignored in software mode");
    // R8 collapse bit ignored in hardware mode
    cfg_write(32'h0013_0003, c0);
    hold_check(30, V_ON, "R8 collapse bit ignored in hw mode");
    set_hw(1'b0, c0);
    push_down(c0 + 1, 0, 1, dn);
    wait_idle();
    cfg_write(32'h0013_0002, c0);
    hold_check(30, V_OFF, "R8 collapse clear ignored in hw mode");
    set_hw(1'b1, c0);
    push_up(c0 + 1, 0, 3, 1, dn);
    wait_idle();
    set_hw(1'b0, c0);
    push_down(c0 + 1, 0, 1, dn);
    wait_idle();
    cfg_write(32'h0013_0001, c0);
    hold_check(20, V_OFF, "R8 back to software mode stays off");

    // R11 write to status bit ignored
    cfg_write(32'h8013_0001, c0);
    check(rd_data === 32'h0013_0001, "R11 status bit read-only", rd_data, 32'h0013_0001);
    hold_check(10, V_OFF, "R11 status write has no effect");

    // R2 long few wait (n=10)
    cfg_write(32'h002A_2000, c0);
    push_up(c0 + 2, 2, 10, 2, dn);
    wait_idle();
    check(pwr_on_status === 1'b1, "R6 settled on after long wait", {31'd0, pwr_on_status}, 32'd1);

    check(exp_q.size() == 0, "R4 all predicted steps seen", exp_q.size(), 32'd0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule